// File: doc/BRIEF.md
# Zoned Track Address Generator

This block turns a track selector into the byte address of one sector inside a flat disk image laid out in zones. The selector packs a track number and a surface (head) bit. The recording density changes across the surface, so each zone has its own sector size and its own starting byte in the image. A bank of threshold comparators finds the zone. The zone's start byte comes from a table that is worked out when the design is elaborated. A single shared multiplier then scales the track, block and sector position into bytes.

A client drives the selector, a block select and a sector index, and pulses `start` for one cycle. A fixed number of cycles later the block raises a one-cycle `done`. In that same cycle it presents the zone, the sector size, the sector byte address and a range-error flag, all from registers. These results stay unchanged until the next job completes. A `start` that arrives while a job is in flight is dropped.

Top module: `trk_addr_gen`

## Requirements
- R1: The track number is `trackHead[11:0]` and the head is `trackHead[12]`. The base zone b (0..7) is the largest b whose threshold does not exceed the track. The thresholds for b=0..7 are 0x000, 0x09E, 0x13C, 0x1D1, 0x266, 0x2FB, 0x390 and 0x425. The reported zone is b + 8 × head.
- R2: The sector size in bytes for zones 0..15 is 232, 216, 208, 192, 176, 160, 144, 128, 216, 208, 192, 176, 160, 144, 128, 112.
- R3: Base zones 0..7 hold 158, 158, 149, 149, 149, 149, 149 and 114 tracks. Each track holds 2 blocks of 85 sectors. Zone z starts where zone z-1 ends, so zone 0 starts at 0x00000000, zone 1 at 0x005F15E0, zone 3 at 0x010801A0, zone 8 at 0x023196E0 and zone 15 at 0x04149200.
- R4: The sector address is zoneStart + sectorBytes × ((track − threshold) × 170 + blockSel × 85 + sectorIdx).
- R5: A `start` sampled at clock edge E in the idle state produces `done` high for exactly one cycle, starting right after edge E+3.
- R6: A track at or beyond its base zone's threshold plus that zone's track count gives `rangeErr`=1 and `sectorAddr`=0. Only the last base zone can reach this, so the first rejected track is 0x497. Zone and size are still reported, and `done` still pulses with the same latency.
- R7: A `start` that arrives while a job is in flight is ignored. Changes on the data inputs after the start cycle do not affect the result.
- R8: All four result outputs hold their values between completions. A `start` in the cycle where `done` is high is accepted.
- R9: While reset is active and after it is released, `done`, `zone`, `sectorBytes`, `sectorAddr` and `rangeErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| trackHead | input | 13 | Head bit 12, track number bits 11:0 |
| blockSel | input | 1 | Block within the track (0 or 1) |
| sectorIdx | input | SECT_W (7) | Sector within the block |
| done | output | 1 | One-cycle completion pulse |
| zone | output | 4 | Zone index 0..15 |
| sectorBytes | output | 8 | Sector size of the zone in bytes |
| sectorAddr | output | ADDR_W (32) | Byte address of the sector, 0 on range error |
| rangeErr | output | 1 | Track beyond the last track of its zone |

## Verification
Two events can fall in the same cycle: the completion pulse of one job and the acceptance of the next job's `start`. The bench raises `start` with a new selector in the very cycle where `done` is seen. It then checks three things: `done` drops on the next cycle, the previous address is still on the outputs while the new job runs, and the new result appears exactly four cycles later. A second case raises `start` one cycle after a job is accepted, with different inputs. The bench confirms that only the first job's result appears and that no second pulse follows.

// File: rtl/trk_addr_pkg.sv
package trk_addr_pkg;

  localparam int TRK_W        = 12;
  localparam int NUM_BASE     = 8;
  localparam int BASE_W       = $clog2(NUM_BASE);
  localparam int NUM_ZONES    = 2 * NUM_BASE;
  localparam int ZONE_W       = $clog2(NUM_ZONES);
  localparam int SIZE_W       = 8;
  localparam int SECT_PER_BLK = 85;
  localparam int BLK_PER_TRK  = 2;
  localparam int SECT_PER_TRK = SECT_PER_BLK * BLK_PER_TRK;
  localparam int ACC_W        = 16;
  localparam int PROD_W       = ACC_W + SIZE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ZONE = 2'd1,
    ST_MULA = 2'd2,
    ST_MULB = 2'd3
  } trk_state_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
    logic zoneStep;
    logic mulStepA;
    logic mulStepB;
  } trk_strobe_t;

  function automatic int baseThreshold(input int b);
    case (b)
      0:       return 'h000;
      1:       return 'h09E;
      2:       return 'h13C;
      3:       return 'h1D1;
      4:       return 'h266;
      5:       return 'h2FB;
      6:       return 'h390;
      default: return 'h425;
    endcase
  endfunction

  function automatic int baseTrackCount(input int b);
    case (b)
      0, 1:    return 158;
      7:       return 114;
      default: return 149;
    endcase
  endfunction

  function automatic int zoneSectorBytes(input int z);
    case (z)
      0:       return 232;
      1, 8:    return 216;
      2, 9:    return 208;
      3, 10:   return 192;
      4, 11:   return 176;
      5, 12:   return 160;
      6, 13:   return 144;
      7, 14:   return 128;
      default: return 112;
    endcase
  endfunction

  // Start byte of a zone: sum of all earlier zones' sizes.
  function automatic int zoneStartBytes(input int z);
    int sum;
    sum = 0;
    for (int k = 0; k < z; k++)
      sum += baseTrackCount(k % NUM_BASE) * zoneSectorBytes(k) * SECT_PER_TRK;
    return sum;
  endfunction

endpackage

// File: rtl/trk_addr_ctrl.sv
module trk_addr_ctrl
  import trk_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output trk_strobe_t stb,
  output logic        done
);

  trk_state_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (start) stateNxt = ST_ZONE;
      ST_ZONE: stateNxt = ST_MULA;
      ST_MULA: stateNxt = ST_MULB;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    stb          = '0;
    stb.capture  = (state == ST_IDLE) && start;
    stb.zoneStep = (state == ST_ZONE);
    stb.mulStepA = (state == ST_MULA);
    stb.mulStepB = (state == ST_MULB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= (state == ST_MULB);
    end
  end

  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_capture_chain_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> stb.zoneStep ##1 stb.mulStepA ##1 stb.mulStepB ##1 done);

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.zoneStep || stb.mulStepA || stb.mulStepB) |-> !stb.capture);

endmodule

// File: rtl/trk_addr_dp.sv
module trk_addr_dp
  import trk_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SECT_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trk_strobe_t          stb,
  input  logic [TRK_W:0]       trackHead,
  input  logic                 blockSel,
  input  logic [SECT_W-1:0]    sectorIdx,
  output logic [ZONE_W-1:0]    zone,
  output logic [SIZE_W-1:0]    sectorBytes,
  output logic [ADDR_W-1:0]    sectorAddr,
  output logic                 rangeErr
);

  // Constant tables, built at elaboration.
  logic [TRK_W-1:0]  thrTbl   [NUM_BASE];
  logic [TRK_W-1:0]  endTbl   [NUM_BASE];
  logic [SIZE_W-1:0] sizeTbl  [NUM_ZONES];
  logic [ADDR_W-1:0] startTbl [NUM_ZONES];

  for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
    assign thrTbl[b] = TRK_W'(baseThreshold(b));
    assign endTbl[b] = TRK_W'(baseThreshold(b) + baseTrackCount(b));
  end

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    assign sizeTbl[z]  = SIZE_W'(zoneSectorBytes(z));
    assign startTbl[z] = ADDR_W'(zoneStartBytes(z));
  end

  // Captured request.
  logic [TRK_W-1:0]  trkR;
  logic              headR;
  logic              blkR;
  logic [SECT_W-1:0] secR;

  // Zone stage.
  logic [ZONE_W-1:0] zoneR;
  logic [TRK_W-1:0]  trOffR;
  logic [SIZE_W-1:0] sizeR;
  logic              errR;
  logic [ACC_W-1:0]  accR;

  // Comparator bank: count thresholds at or below the track.
  logic [NUM_BASE-1:0] geVec;
  logic [BASE_W-1:0]   baseZone;

  for (genvar b = 0; b < NUM_BASE; b++) begin : g_cmp
    assign geVec[b] = (trkR >= thrTbl[b]);
  end

  assign baseZone = BASE_W'($countones(geVec) - 1);

  // Shared multiplier, operands chosen by stage.
  logic [ACC_W-1:0]  mulA;
  logic [SIZE_W-1:0] mulB;
  logic [PROD_W-1:0] product;

  assign mulA    = stb.mulStepB ? accR  : ACC_W'(trOffR);
  assign mulB    = stb.mulStepB ? sizeR : SIZE_W'(SECT_PER_TRK);
  assign product = PROD_W'(mulA) * PROD_W'(mulB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trkR        <= '0;
      headR       <= 1'b0;
      blkR        <= 1'b0;
      secR        <= '0;
      zoneR       <= '0;
      trOffR      <= '0;
      sizeR       <= '0;
      errR        <= 1'b0;
      accR        <= '0;
      zone        <= '0;
      sectorBytes <= '0;
      sectorAddr  <= '0;
      rangeErr    <= 1'b0;
    end else begin
      if (stb.capture) begin
        trkR  <= trackHead[TRK_W-1:0];
        headR <= trackHead[TRK_W];
        blkR  <= blockSel;
        secR  <= sectorIdx;
      end
      if (stb.zoneStep) begin
        zoneR  <= {headR, baseZone};
        trOffR <= trkR - thrTbl[baseZone];
        sizeR  <= sizeTbl[{headR, baseZone}];
        errR   <= (trkR >= endTbl[baseZone]);
      end
      if (stb.mulStepA) begin
        accR <= ACC_W'(product)
              + (blkR ? ACC_W'(SECT_PER_BLK) : '0)
              + ACC_W'(secR);
      end
      if (stb.mulStepB) begin
        zone        <= zoneR;
        sectorBytes <= sizeR;
        rangeErr    <= errR;
        sectorAddr  <= errR ? '0 : startTbl[zoneR] + ADDR_W'(product);
      end
    end
  end

  p_zone_head_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.zoneStep |=> (zoneR[ZONE_W-1] == headR));

  p_err_addr_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mulStepB && errR) |=> (rangeErr && sectorAddr == '0));

  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.mulStepB |=> ($stable(sectorAddr) && $stable(zone)
                       && $stable(sectorBytes) && $stable(rangeErr)));

  p_size_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.mulStepB |=> (sectorBytes >= SIZE_W'(112)));

endmodule

// File: rtl/trk_addr_gen.sv
module trk_addr_gen
  import trk_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SECT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [12:0]       trackHead,
  input  logic              blockSel,
  input  logic [SECT_W-1:0] sectorIdx,
  output logic              done,
  output logic [3:0]        zone,
  output logic [7:0]        sectorBytes,
  output logic [ADDR_W-1:0] sectorAddr,
  output logic              rangeErr
);

  trk_strobe_t stb;

  trk_addr_ctrl i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stb   (stb),
    .done  (done)
  );

  trk_addr_dp #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .trackHead   (trackHead),
    .blockSel    (blockSel),
    .sectorIdx   (sectorIdx),
    .zone        (zone),
    .sectorBytes (sectorBytes),
    .sectorAddr  (sectorAddr),
    .rangeErr    (rangeErr)
  );

endmodule

// File: tb/test_trk_addr_gen.sv
`timescale 1ns/1ps
module test_trk_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [12:0] trackHead = '0;
  logic        blockSel = 1'b0;
  logic [6:0]  sectorIdx = '0;
  logic        done;
  logic [3:0]  zone;
  logic [7:0]  sectorBytes;
  logic [31:0] sectorAddr;
  logic        rangeErr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trk_addr_gen i_trk_addr_gen (
    .clk(clk), .rstN(rstN), .start(start), .trackHead(trackHead),
    .blockSel(blockSel), .sectorIdx(sectorIdx), .done(done), .zone(zone),
    .sectorBytes(sectorBytes), .sectorAddr(sectorAddr), .rangeErr(rangeErr)
  );

  // {head, track, blk, sec, zone, size, addr, err}
  localparam int VW = 1 + 12 + 1 + 7 + 4 + 8 + 32 + 1;
  localparam int NV = 12;
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b0, 12'h000, 1'b0, 7'd0,  4'd0,  8'd232, 32'h00000000, 1'b0},
    {1'b0, 12'h09D, 1'b1, 7'd84, 4'd0,  8'd232, 32'h005F14F8, 1'b0},
    {1'b0, 12'h09E, 1'b0, 7'd0,  4'd1,  8'd216, 32'h005F15E0, 1'b0},
    {1'b0, 12'h13C, 1'b0, 7'd1,  4'd2,  8'd208, 32'h00B79DD0, 1'b0},
    {1'b0, 12'h1D1, 1'b0, 7'd0,  4'd3,  8'd192, 32'h010801A0, 1'b0},
    {1'b0, 12'h496, 1'b1, 7'd84, 4'd7,  8'd128, 32'h02319660, 1'b0},
    {1'b1, 12'h000, 1'b0, 7'd0,  4'd8,  8'd216, 32'h023196E0, 1'b0},
    {1'b1, 12'h09F, 1'b0, 7'd2,  4'd9,  8'd208, 32'h028AA9C0, 1'b0},
    {1'b1, 12'h425, 1'b0, 7'd0,  4'd15, 8'd112, 32'h04149200, 1'b0},
    {1'b0, 12'h00A, 1'b1, 7'd0,  4'd0,  8'd232, 32'h000651A8, 1'b0},
    {1'b0, 12'h497, 1'b0, 7'd0,  4'd7,  8'd128, 32'h00000000, 1'b1},
    {1'b1, 12'hFFF, 1'b1, 7'd5,  4'd15, 8'd112, 32'h00000000, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    trackHead = {v[65], v[64:53]};
    blockSel  = v[52];
    sectorIdx = v[51:45];
    start     = 1'b1;
  endtask

  // Called at a negedge; returns the negedge count until done.
  task automatic waitDone(output int lat);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic checkResult(input logic [VW-1:0] v, input string note);
    chk({"R1 zone ", note}, 32'(zone), 32'(v[44:41]));
    chk({"R2 size ", note}, 32'(sectorBytes), 32'(v[40:33]));
    chk({"R4/R3 addr ", note}, sectorAddr, v[32:1]);
    chk({"R6 err ", note}, 32'(rangeErr), 32'(v[0]));
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int lat;
    int pulses;
    logic [31:0] held;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 done in reset", 32'(done), 0);
    chk("R9 addr in reset", sectorAddr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 done after reset", 32'(done), 0);
    chk("R9 zone after reset", 32'(zone), 0);
    chk("R9 size after reset", 32'(sectorBytes), 0);
    chk("R9 err after reset", 32'(rangeErr), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      waitDone(lat);
      chk($sformatf("R5 latency vec%0d", i), 32'(lat), 4);
      checkResult(VECS[i], $sformatf("vec%0d", i));
      @(negedge clk);
      chk($sformatf("R5 done pulse vec%0d", i), 32'(done), 0);
    end

    // R8: outputs hold while idle
    held = sectorAddr;
    repeat (6) @(negedge clk);
    chk("R8 hold addr idle", sectorAddr, held);
    chk("R8 hold err idle", 32'(rangeErr), 1);

    // R7: start while busy is ignored
    drive(VECS[3]);
    @(negedge clk);
    drive(VECS[8]);
    @(negedge clk);
    start = 1'b0;
    trackHead = 13'h1FFF;
    lat = 2;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 latency kept", 32'(lat), 4);
    checkResult(VECS[3], "busy start R7");
    pulses = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk("R7 no extra done", 32'(pulses), 0);

    // R8: back-to-back, start in the done cycle
    drive(VECS[7]);
    waitDone(lat);
    chk("R5 latency first", 32'(lat), 4);
    held = sectorAddr;
    drive(VECS[5]);
    @(negedge clk);
    start = 1'b0;
    chk("R8 done falls", 32'(done), 0);
    chk("R8 old addr held", sectorAddr, held);
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 back-to-back latency", 32'(lat), 4);
    checkResult(VECS[5], "back-to-back R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule